// File: doc/BRIEF.md
# Frame Check Sequence Appender with Fault Injection

This block sits on a byte-wide packet stream and adds a frame check sequence to each packet. Bytes enter with a ready/valid handshake and start-of-packet and end-of-packet markers. Each byte is copied to a registered output stage. While the byte is copied, a running CRC is folded over the packet. When the last byte of a packet has been accepted, the block stalls its input and emits the inverted CRC as two or four extra bytes. The end marker moves onto the final check byte.

For link testing, the block can deliberately damage the check field. In an errored packet exactly one bit of the appended field is flipped. The flipped position advances by one with every errored packet, so repeated faults sweep the whole field. The trigger for damage has two sources. In manual mode, a strobe input marks the next appended packet. In scheduled mode, an arm pulse loads an error budget and a gap, and the block then damages packets on its own.

Top module: `fcs_appender`

## Requirements
- R1: With the 32-bit check selected, the CRC is the reflected form of x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1. Data bits are taken least significant first and the register is preset to all ones at each packet start. The register is complemented and appended as four bytes, least significant byte first. For the ASCII bytes "123456789" the appended bytes are 26 39 F4 CB.
- R2: With the 16-bit check selected, the same rules apply to x^16+x^12+x^5+1 and two bytes are appended. For "123456789" the appended bytes are 6E 90.
- R3: With processing enabled and append disabled, a packet leaves unchanged and no check bytes follow it. Such a packet neither consumes a pending manual error nor advances the scheduler or the bit position.
- R4: With processing disabled, a packet leaves unchanged with no check bytes, whatever the append setting.
- R5: In manual mode (cfg_sched_mode=0), a one-cycle pulse on err_strobe marks the next appended packet. In that packet exactly one check bit is inverted. Later packets are clean until another pulse arrives.
- R6: The corrupted bit position is counted in the check value, where bit 0 is bit 0 of the first appended byte. It is 0 after reset and rises by one after each errored packet. It wraps modulo the width of the check selected for that packet (16 or 32).
- R7: In scheduled mode, a sched_arm pulse loads cfg_err_count errors and a gap of cfg_err_gap. The first appended packet after the arm is errored. Each further error follows exactly cfg_err_gap clean appended packets. Damage stops after cfg_err_count errored packets.
- R8: In scheduled mode, err_strobe pulses are ignored and are not remembered for later.
- R9: Under any out_ready pattern, no byte is lost or duplicated. in_ready is low while check bytes are being emitted. A held output does not change. out_sop marks only the first byte of a packet, and out_eop marks only its final emitted byte.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_proc_en | input | 1 | Enables check processing |
| cfg_append_en | input | 1 | Enables appending of the check field |
| cfg_crc32 | input | 1 | 1 selects the 32-bit check, 0 the 16-bit check |
| cfg_sched_mode | input | 1 | 1 selects scheduled injection, 0 manual |
| cfg_err_count | input | CNT_W | Number of errors loaded on arm |
| cfg_err_gap | input | CNT_W | Clean appended packets between errors |
| sched_arm | input | 1 | Pulse that loads the scheduler |
| err_strobe | input | 1 | Manual error request pulse |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of packet |
| in_eop | input | 1 | Last byte of packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of output packet |
| out_eop | output | 1 | Last byte of output packet |

## Verification
The bench uses the two nine-byte check strings to catch a wrong polynomial, a wrong preset, a missing complement or a swapped byte order. Any of these faults gives different trailing bytes. The bench runs one-byte packets, where start and end arrive in the same beat. A design that sampled the mode or the injection decision one beat late would produce a wrong check value there. Seventeen errored 16-bit packets in a row show whether the bit position wraps at sixteen; a design with a fixed 32-bit wrap would flip a bit outside the field. The bench also checks that a pending strobe survives a packet sent without append, and that strobes given in scheduled mode are dropped. A design that consumed the pending strobe, or stored the ignored ones, would damage the wrong packet.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int BYTE_W = 8;
    localparam int FCS_MAX_W = 32;
    localparam int IDX_W = $clog2(FCS_MAX_W);
    localparam logic [FCS_MAX_W-1:0] POLY32_REFL = 32'hEDB8_8320;
    localparam logic [FCS_MAX_W-1:0] POLY16_REFL = 32'h0000_8408;

    typedef enum logic {ST_PASS, ST_FCS} phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic [FCS_MAX_W-1:0]   crc;
        logic                   app;
        logic                   is32;
        logic [FCS_MAX_W-1:0]   fcs_sh;
        logic [2:0]             left;
        logic                   ovalid;
        logic [BYTE_W-1:0]      odata;
        logic                   osop;
        logic                   oeop;
    } path_regs_t;
endpackage

// File: rtl/fcs_crc_step.sv
module fcs_crc_step
    import fcs_pkg::*;
(
    input  logic [FCS_MAX_W-1:0] crc_in,
    input  logic [BYTE_W-1:0]    data,
    input  logic                 is32,
    output logic [FCS_MAX_W-1:0] crc_out
);
    always_comb begin
        logic [FCS_MAX_W-1:0] c;
        logic fb;
        c = crc_in;
        for (int b = 0; b < BYTE_W; b++) begin
            fb = c[0] ^ data[b];
            c  = c >> 1;
            if (fb) c = c ^ (is32 ? POLY32_REFL : POLY16_REFL);
        end
        crc_out = c;
    end
endmodule

// File: rtl/fcs_err_sched.sv
module fcs_err_sched
    import fcs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sched_mode,
    input  logic             arm,
    input  logic             strobe,
    input  logic [CNT_W-1:0] err_count,
    input  logic [CNT_W-1:0] err_gap,
    input  logic             pkt_go,
    input  logic             pkt_is32,
    output logic             err_now,
    output logic [IDX_W-1:0] bit_idx
);
    typedef struct packed {
        logic [CNT_W-1:0] remain;
        logic [CNT_W-1:0] gap;
        logic             pend;
        logic [IDX_W-1:0] idx;
    } sched_regs_t;

    sched_regs_t s_q, s_d;

    logic sched_hit;
    assign sched_hit = !arm && (s_q.remain != '0) && (s_q.gap == '0);
    assign err_now   = sched_mode ? sched_hit : s_q.pend;
    assign bit_idx   = s_q.idx;

    always_comb begin
        s_d = s_q;
        if (sched_mode && arm) begin
            s_d.remain = err_count;
            s_d.gap    = '0;
        end else if (sched_mode && pkt_go && s_q.remain != '0) begin
            if (s_q.gap == '0) begin
                s_d.remain = s_q.remain - 1'b1;
                s_d.gap    = err_gap;
            end else begin
                s_d.gap = s_q.gap - 1'b1;
            end
        end
        if (!sched_mode) begin
            s_d.pend = (s_q.pend && !pkt_go) || strobe;
        end
        if (pkt_go && err_now) begin
            if (pkt_is32) s_d.idx = s_q.idx + 1'b1;
            else          s_d.idx = {1'b0, s_q.idx[IDX_W-2:0] + 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_budget_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> s_q.remain <= $past(s_q.remain));
    p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_go && err_now) |=> $stable(s_q.idx));
    p_strobe_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_mode && !s_q.pend) |=> !s_q.pend);
endmodule

// File: rtl/fcs_appender.sv
module fcs_appender
    import fcs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_proc_en,
    input  logic             cfg_append_en,
    input  logic             cfg_crc32,
    input  logic             cfg_sched_mode,
    input  logic [CNT_W-1:0] cfg_err_count,
    input  logic [CNT_W-1:0] cfg_err_gap,
    input  logic             sched_arm,
    input  logic             err_strobe,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop
);
    localparam logic [2:0] BYTES32 = 3'(FCS_MAX_W / BYTE_W);
    localparam logic [2:0] BYTES16 = 3'(16 / BYTE_W);

    path_regs_t r_q, r_d;

    logic                 slot_free, acc, pkt_go;
    logic                 cur_app, cur32, sched_err;
    logic [IDX_W-1:0]     sched_idx;
    logic [FCS_MAX_W-1:0] crc_base, crc_nx, fcs_val;
    logic [IDX_W-1:0]     flip_pos;

    assign slot_free = !r_q.ovalid || out_ready;
    assign in_ready  = (r_q.phase == ST_PASS) && slot_free;
    assign acc       = in_valid && in_ready;
    assign cur_app   = in_sop ? (cfg_proc_en && cfg_append_en) : r_q.app;
    assign cur32     = in_sop ? cfg_crc32 : r_q.is32;
    assign crc_base  = in_sop ? (cfg_crc32 ? 32'hFFFF_FFFF : 32'h0000_FFFF) : r_q.crc;
    assign pkt_go    = acc && in_sop && cfg_proc_en && cfg_append_en;

    fcs_crc_step u_step (
        .crc_in (crc_base),
        .data   (in_data),
        .is32   (cur32),
        .crc_out(crc_nx)
    );

    fcs_err_sched #(.CNT_W(CNT_W)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .sched_mode(cfg_sched_mode),
        .arm       (sched_arm),
        .strobe    (err_strobe),
        .err_count (cfg_err_count),
        .err_gap   (cfg_err_gap),
        .pkt_go    (pkt_go),
        .pkt_is32  (cfg_crc32),
        .err_now   (sched_err),
        .bit_idx   (sched_idx)
    );

    // The fault decision and position are taken on the start beat and held for the packet.
    logic                 err_held_q, err_held_d;
    logic [IDX_W-1:0]     pos_held_q, pos_held_d;
    logic                 cur_err;
    logic [IDX_W-1:0]     cur_pos;

    assign cur_err  = in_sop ? (pkt_go && sched_err) : err_held_q;
    assign cur_pos  = in_sop ? sched_idx : pos_held_q;
    assign flip_pos = cur32 ? cur_pos : {1'b0, cur_pos[IDX_W-2:0]};

    always_comb begin
        logic [FCS_MAX_W-1:0] mask;
        mask    = cur32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        fcs_val = ~crc_nx & mask;
        if (cur_err) fcs_val = fcs_val ^ (32'd1 << flip_pos);
    end

    always_comb begin
        r_d        = r_q;
        err_held_d = err_held_q;
        pos_held_d = pos_held_q;
        if (out_ready) r_d.ovalid = 1'b0;
        unique case (r_q.phase)
            ST_PASS: begin
                if (acc) begin
                    r_d.crc    = crc_nx;
                    r_d.app    = cur_app;
                    r_d.is32   = cur32;
                    r_d.ovalid = 1'b1;
                    r_d.odata  = in_data;
                    r_d.osop   = in_sop;
                    r_d.oeop   = in_eop && !cur_app;
                    err_held_d = cur_err;
                    pos_held_d = cur_pos;
                    if (in_eop && cur_app) begin
                        r_d.fcs_sh = fcs_val;
                        r_d.left   = cur32 ? BYTES32 : BYTES16;
                        r_d.phase  = ST_FCS;
                    end
                end
            end
            ST_FCS: begin
                if (slot_free) begin
                    r_d.ovalid = 1'b1;
                    r_d.odata  = r_q.fcs_sh[BYTE_W-1:0];
                    r_d.osop   = 1'b0;
                    r_d.oeop   = (r_q.left == 3'd1);
                    r_d.fcs_sh = r_q.fcs_sh >> BYTE_W;
                    r_d.left   = r_q.left - 3'd1;
                    if (r_q.left == 3'd1) r_d.phase = ST_PASS;
                end
            end
            default: r_d.phase = ST_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            err_held_q <= 1'b0;
            pos_held_q <= '0;
        end else begin
            r_q        <= r_d;
            err_held_q <= err_held_d;
            pos_held_q <= pos_held_d;
        end
    end

    assign out_valid = r_q.ovalid;
    assign out_data  = r_q.odata;
    assign out_sop   = r_q.osop;
    assign out_eop   = r_q.oeop;

    p_stall_in_fcs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == ST_FCS) |-> !in_ready);
    p_hold_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop) && $stable(out_sop)));
    p_copy_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
    p_check_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eop && cur_app) |=> (!in_ready && !out_eop));
    p_no_check_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sop && !cfg_proc_en) |=> (r_q.phase == ST_PASS));
endmodule

// File: tb/tb_fcs_appender.sv
module tb_fcs_appender;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;

    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_proc_en = 1'b1, cfg_append_en = 1'b1, cfg_crc32 = 1'b1, cfg_sched_mode = 1'b0;
    logic [CNT_W-1:0] cfg_err_count = '0, cfg_err_gap = '0;
    logic sched_arm = 1'b0, err_strobe = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b1;
    logic [7:0] in_data = '0;
    logic in_ready, out_valid, out_sop, out_eop;
    logic [7:0] out_data;

    int n_vec = 0, n_bad = 0;
    bit stall = 0, done = 0;
    int model_idx = 0;
    logic [7:0] rx_d[$];
    bit rx_s[$], rx_e[$];

    fcs_appender #(.CNT_W(CNT_W)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            rx_d.push_back(out_data);
            rx_s.push_back(out_sop);
            rx_e.push_back(out_eop);
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_crc(bq_t d, bit w32);
        logic [31:0] c = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        foreach (d[i]) for (int b = 0; b < 8; b++) begin
            bit fb = c[0] ^ d[i][b];
            c = c >> 1;
            if (fb) c = c ^ (w32 ? 32'hEDB8_8320 : 32'h0000_8408);
        end
        return w32 ? ~c : (~c & 32'h0000_FFFF);
    endfunction

    // Builds the expected byte stream; advances the bench's own bit position on errors.
    function automatic bq_t expect_pkt(bq_t d, bit app, bit w32, bit err);
        bq_t e = d;
        if (app) begin
            int w = w32 ? 32 : 16;
            logic [31:0] f = model_crc(d, w32);
            if (err) begin
                int pos = model_idx % w;
                f = f ^ (32'd1 << pos);
                model_idx = (pos + 1) % w;
            end
            for (int k = 0; k < w / 8; k++) e.push_back(f[8*k +: 8]);
        end
        return e;
    endfunction

    task automatic pulse(ref logic s);
        @(posedge clk); #1 s = 1'b1;
        @(posedge clk); #1 s = 1'b0;
    endtask

    task automatic send_check(input bq_t d, input bq_t exp, input string req);
        for (int i = 0; i < d.size(); i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_data = d[i];
            in_sop = (i == 0); in_eop = (i == d.size() - 1);
            do @(negedge clk); while (!in_ready);
        end
        @(posedge clk); #1 in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        for (int t = 0; t < 400 && rx_d.size() < exp.size(); t++) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(rx_d.size() == exp.size(), req, "byte count", rx_d.size(), exp.size());
        for (int i = 0; i < exp.size() && i < rx_d.size(); i++) begin
            chk(rx_d[i] == exp[i], req, $sformatf("byte %0d", i), rx_d[i], exp[i]);
            chk(rx_s[i] == (i == 0), req, $sformatf("sop %0d", i), rx_s[i], i == 0);
            chk(rx_e[i] == (i == exp.size() - 1), req, $sformatf("eop %0d", i), rx_e[i], i == exp.size() - 1);
        end
        rx_d.delete(); rx_s.delete(); rx_e.delete();
    endtask

    function automatic bq_t ascii_digits();
        bq_t q;
        for (int i = 1; i <= 9; i++) q.push_back(8'h30 + 8'(i));
        return q;
    endfunction

    function automatic bq_t mk_pkt(int len, int seed);
        bq_t q;
        for (int i = 0; i < len; i++) q.push_back(8'((seed * 37 + i * 91 + 5) & 8'hFF));
        return q;
    endfunction

    task automatic t_reset();
        chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    endtask

    task automatic t_crc32();
        bq_t e;
        bq_t lit;
        cfg_crc32 = 1'b1;
        lit = ascii_digits();
        lit.push_back(8'h26); lit.push_back(8'h39); lit.push_back(8'hF4); lit.push_back(8'hCB);
        send_check(ascii_digits(), lit, "R1");
        e = expect_pkt(mk_pkt(23, 3), 1, 1, 0);
        send_check(mk_pkt(23, 3), e, "R1");
        e = expect_pkt(mk_pkt(1, 9), 1, 1, 0);
        send_check(mk_pkt(1, 9), e, "R1 one-byte");
    endtask

    task automatic t_crc16();
        bq_t lit;
        cfg_crc32 = 1'b0;
        lit = ascii_digits();
        lit.push_back(8'h6E); lit.push_back(8'h90);
        send_check(ascii_digits(), lit, "R2");
        send_check(mk_pkt(6, 4), expect_pkt(mk_pkt(6, 4), 1, 0, 0), "R2");
        cfg_crc32 = 1'b1;
    endtask

    task automatic t_backpressure();
        stall = 1;
        for (int p = 0; p < 4; p++) begin
            cfg_crc32 = p[0];
            send_check(mk_pkt(3 + p * 5, 20 + p), expect_pkt(mk_pkt(3 + p * 5, 20 + p), 1, p[0], 0), "R9");
        end
        stall = 0;
        cfg_crc32 = 1'b1;
    endtask

    task automatic t_manual();
        pulse(err_strobe);
        send_check(mk_pkt(5, 40), expect_pkt(mk_pkt(5, 40), 1, 1, 1), "R5 errored");
        send_check(mk_pkt(5, 41), expect_pkt(mk_pkt(5, 41), 1, 1, 0), "R5 clean after");
        pulse(err_strobe);
        send_check(mk_pkt(7, 42), expect_pkt(mk_pkt(7, 42), 1, 1, 1), "R6 second position");
    endtask

    task automatic t_append_off();
        pulse(err_strobe);
        cfg_append_en = 1'b0;
        send_check(mk_pkt(6, 50), mk_pkt(6, 50), "R3 no check bytes");
        cfg_append_en = 1'b1;
        send_check(mk_pkt(6, 51), expect_pkt(mk_pkt(6, 51), 1, 1, 1), "R3 strobe kept");
    endtask

    task automatic t_proc_off();
        cfg_proc_en = 1'b0;
        send_check(mk_pkt(8, 60), mk_pkt(8, 60), "R4 append on");
        cfg_append_en = 1'b0;
        send_check(mk_pkt(2, 61), mk_pkt(2, 61), "R4 append off");
        cfg_append_en = 1'b1; cfg_proc_en = 1'b1;
    endtask

    task automatic t_sched();
        cfg_sched_mode = 1'b1; cfg_err_count = 8'd3; cfg_err_gap = 8'd2;
        pulse(sched_arm);
        for (int p = 0; p < 10; p++) begin
            bit e = (p == 0 || p == 3 || p == 6);
            send_check(mk_pkt(4, 70 + p), expect_pkt(mk_pkt(4, 70 + p), 1, 1, e), "R7");
        end
        pulse(err_strobe);
        send_check(mk_pkt(4, 85), expect_pkt(mk_pkt(4, 85), 1, 1, 0), "R8 strobe in sched");
        cfg_sched_mode = 1'b0;
        send_check(mk_pkt(4, 86), expect_pkt(mk_pkt(4, 86), 1, 1, 0), "R8 not remembered");
    endtask

    task automatic t_wrap();
        cfg_crc32 = 1'b0; cfg_sched_mode = 1'b1; cfg_err_count = 8'd17; cfg_err_gap = 8'd0;
        pulse(sched_arm);
        for (int p = 0; p < 18; p++)
            send_check(mk_pkt(1, 90 + p), expect_pkt(mk_pkt(1, 90 + p), 1, 0, p < 17), "R6 wrap");
        cfg_sched_mode = 1'b0; cfg_crc32 = 1'b1;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_crc32();
        t_crc16();
        t_backpressure();
        t_manual();
        t_append_off();
        t_proc_off();
        t_sched();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule